// File: doc/BRIEF.md
# Hot-plug slot register controller

This block holds the slot command and slot status registers of a hot-plug capable downstream or root port. Configuration software writes the command register (indicator states, power controller state, per-event interrupt enables, interlock command) and clears status events by writing ones. The slot side reports a hot insertion and attention-button presses as single-cycle pulses. Each write to the command register counts as one command and completes in the same cycle.

The block raises an interrupt condition from the latched status events and their enables. It signals a change of that condition either on a level interrupt line or, when message interrupts are enabled, as a one-cycle request pulse. It requests a detach when software powers off a populated slot. It also drops a status clear that would lose events software has not yet seen.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset the command register reads 0x00C0 (attention indicator field [7:6] = 11b, off; every other field 0), the status register reads 0x0000, and linkActive, intLevel, msiReq and detachReq are 0.
- R2: A command write (cfgSel = 0) updates only the byte lanes whose cfgByteEn bit is set. Writable fields are enables [5:0] (bit0 attention, bit1 power fault, bit2 latch change, bit3 presence change, bit4 command done, bit5 master hot-plug enable), attention indicator [7:6], power indicator [9:8] and power controller off [10]. Bits [15:11] always read 0.
- R3: Status bits [4:0] are events (bit0 attention pressed, bit1 power fault, bit2 latch changed, bit3 presence changed, bit4 command done). A status write (cfgSel = 1, cfgByteEn[0] = 1) clears each event whose data bit is 1. Presence state [6] and interlock state [7] are not changed by status writes, and bit 5 reads 0.
- R4: A command write with cfgByteEn[1] = 1 and data bit 11 = 1 inverts interlock state (status bit 7).
- R5: Every command write with at least one byte enable sets the command-done event.
- R6: A command write sets detachReq for one cycle if all of these hold: the slot is present, the resulting power controller bit is 1, the resulting power indicator is 11b (off), and the previous value was not already both off. The same cycle clears presence state and linkActive and sets the presence-changed event.
- R7: A status write that carries a 1 for any event bit that is currently 0 leaves all event bits unchanged.
- R8: A hotInsert pulse sets presence state and linkActive, and sets the presence-changed and attention-pressed events.
- R9: An attnPress pulse sets the attention-pressed event. Raising an event that is already set produces no notification.
- R10: The interrupt condition is bit 5 of the command register AND the OR over (event bit AND matching enable). With msiEnable low, intLevel equals the condition one cycle after the registers change.
- R11: With msiEnable high, intLevel is 0 and msiReq pulses for one cycle on each change of the condition, one cycle after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 = command register, 1 = status register |
| cfgByteEn | input | 2 | Byte-lane enables of the write |
| cfgWrData | input | 16 | Write data |
| msiEnable | input | 1 | Message interrupts enabled |
| hotInsert | input | 1 | Pulse: card inserted |
| attnPress | input | 1 | Pulse: attention button pressed |
| ctlRdData | output | 16 | Command register value |
| staRdData | output | 16 | Status register value |
| linkActive | output | 1 | Data link active state |
| intLevel | output | 1 | Level interrupt |
| msiReq | output | 1 | One-cycle message interrupt request |
| detachReq | output | 1 | One-cycle detach request |

## Verification
The bench builds the block with the package defaults: a 16-bit register split into two 8-bit lanes, and five event bits. With this width every byte-enable combination can be issued. The interlock command in the upper lane can be written without touching the enables in the lower lane, and a write that changes only the power fields can be used to reach the detach condition. Because there are five events, a random status write that tries to clear an event that is not set occurs often, so the lost-event guard is exercised many times.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W  = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = REG_W / LANE_W;
  localparam int EVT_W  = 5;

  // event positions, shared by status events and command enables
  localparam int EV_ATTN = 0;
  localparam int EV_PRES = 3;
  localparam int EV_CMD  = 4;

  // status state bits
  localparam int ST_PRESENT = 6;
  localparam int ST_LOCK    = 7;

  // command fields
  localparam int CT_MASTER  = 5;
  localparam int CT_PWR_IND = 8;
  localparam int CT_PWR_OFF = 10;
  localparam int CT_LOCK    = 11;

  localparam logic [1:0] IND_OFF = 2'b11;
  localparam logic [REG_W-1:0] CTL_WMASK = REG_W'(16'h07FF);
  localparam logic [REG_W-1:0] CTL_RESET = REG_W'(16'h00C0);

  typedef struct packed {
    logic             ctlWr;
    logic [REG_W-1:0] ctlNew;
    logic             staWr;
    logic             staGuard;
    logic             lockToggle;
    logic             detach;
    logic             insert;
    logic             attn;
  } hpStrobe_t;
endpackage

// File: rtl/hp_slot_ctl.sv
module hp_slot_ctl
  import hp_slot_pkg::*;
(
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [LANES-1:0] cfgByteEn,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             hotInsert,
  input  logic             attnPress,
  input  logic [REG_W-1:0] ctlQ,
  input  logic [EVT_W-1:0] evtQ,
  input  logic             presentQ,
  output hpStrobe_t        strobe
);
  logic [REG_W-1:0] merged;
  logic             ctlWr;
  logic             offNew;
  logic             offOld;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] =
      cfgByteEn[l] ? cfgWrData[l*LANE_W +: LANE_W] : ctlQ[l*LANE_W +: LANE_W];
  end

  assign ctlWr  = cfgWrEn && !cfgSel && (|cfgByteEn);
  assign offNew = merged[CT_PWR_OFF] && (merged[CT_PWR_IND +: 2] == IND_OFF);
  assign offOld = ctlQ[CT_PWR_OFF] && (ctlQ[CT_PWR_IND +: 2] == IND_OFF);

  always_comb begin
    strobe            = '0;
    strobe.ctlWr      = ctlWr;
    strobe.ctlNew     = merged & CTL_WMASK;
    strobe.staWr      = cfgWrEn && cfgSel && cfgByteEn[0];
    strobe.staGuard   = |(cfgWrData[EVT_W-1:0] & ~evtQ);
    strobe.lockToggle = ctlWr && cfgByteEn[CT_LOCK / LANE_W] && cfgWrData[CT_LOCK];
    strobe.detach     = ctlWr && presentQ && offNew && !offOld;
    strobe.insert     = hotInsert;
    strobe.attn       = attnPress;
  end
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  hpStrobe_t        strobe,
  input  logic [EVT_W-1:0] clrData,
  input  logic             msiEnable,
  output logic [REG_W-1:0] ctlQ,
  output logic [EVT_W-1:0] evtQ,
  output logic             presentQ,
  output logic [REG_W-1:0] staRd,
  output logic             linkActive,
  output logic             intLevel,
  output logic             msiReq,
  output logic             detachReq
);
  logic [REG_W-1:0] ctlReg, ctlNx;
  logic [EVT_W-1:0] evtReg, evtNx;
  logic presReg, presNx, lockReg, lockNx, linkReg, linkNx;
  logic condNow, condPrev;

  assign condNow = ctlReg[CT_MASTER] && (|(evtReg & ctlReg[EVT_W-1:0]));

  always_comb begin
    ctlNx  = ctlReg;
    evtNx  = evtReg;
    presNx = presReg;
    lockNx = lockReg ^ strobe.lockToggle;
    linkNx = linkReg;
    if (strobe.staWr && !strobe.staGuard) evtNx = evtNx & ~clrData;
    if (strobe.ctlWr) begin
      ctlNx = strobe.ctlNew;
      if (strobe.detach) begin
        presNx = 1'b0;
        linkNx = 1'b0;
        evtNx[EV_PRES] = 1'b1;
      end
      evtNx[EV_CMD] = 1'b1;
    end
    if (strobe.insert) begin
      presNx = 1'b1;
      linkNx = 1'b1;
      evtNx[EV_PRES] = 1'b1;
      evtNx[EV_ATTN] = 1'b1;
    end
    if (strobe.attn) evtNx[EV_ATTN] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg    <= CTL_RESET;
      evtReg    <= '0;
      presReg   <= 1'b0;
      lockReg   <= 1'b0;
      linkReg   <= 1'b0;
      condPrev  <= 1'b0;
      intLevel  <= 1'b0;
      msiReq    <= 1'b0;
      detachReq <= 1'b0;
    end else begin
      ctlReg    <= ctlNx;
      evtReg    <= evtNx;
      presReg   <= presNx;
      lockReg   <= lockNx;
      linkReg   <= linkNx;
      condPrev  <= condNow;
      intLevel  <= !msiEnable && condNow;
      msiReq    <= msiEnable && (condNow != condPrev);
      detachReq <= strobe.ctlWr && strobe.detach;
    end
  end

  always_comb begin
    staRd                  = '0;
    staRd[EVT_W-1:0]       = evtReg;
    staRd[ST_PRESENT]      = presReg;
    staRd[ST_LOCK]         = lockReg;
  end

  assign ctlQ       = ctlReg;
  assign evtQ       = evtReg;
  assign presentQ   = presReg;
  assign linkActive = linkReg;
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [LANES-1:0] cfgByteEn,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             msiEnable,
  input  logic             hotInsert,
  input  logic             attnPress,
  output logic [REG_W-1:0] ctlRdData,
  output logic [REG_W-1:0] staRdData,
  output logic             linkActive,
  output logic             intLevel,
  output logic             msiReq,
  output logic             detachReq
);
  hpStrobe_t        strobe;
  logic [REG_W-1:0] ctlQ;
  logic [EVT_W-1:0] evtQ;
  logic             presentQ;

  hp_slot_ctl i_ctl (
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgByteEn (cfgByteEn),
    .cfgWrData (cfgWrData),
    .hotInsert (hotInsert),
    .attnPress (attnPress),
    .ctlQ      (ctlQ),
    .evtQ      (evtQ),
    .presentQ  (presentQ),
    .strobe    (strobe)
  );

  hp_slot_regs i_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .clrData    (cfgWrData[EVT_W-1:0]),
    .msiEnable  (msiEnable),
    .ctlQ       (ctlQ),
    .evtQ       (evtQ),
    .presentQ   (presentQ),
    .staRd      (staRdData),
    .linkActive (linkActive),
    .intLevel   (intLevel),
    .msiReq     (msiReq),
    .detachReq  (detachReq)
  );

  assign ctlRdData = ctlQ;
endmodule

// File: rtl/hp_slot_checker.sv
module hp_slot_checker
  import hp_slot_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic             cfgSel,
  input logic [LANES-1:0] cfgByteEn,
  input logic [EVT_W-1:0] evtData,
  input logic             lockBit,
  input logic             msiEnable,
  input logic             hotInsert,
  input logic             attnPress,
  input logic [EVT_W-1:0] evtRd,
  input logic             presRd,
  input logic             lockRd,
  input logic             linkActive,
  input logic             intLevel,
  input logic             detachReq
);
  // R5: any command write leaves the command-done event set
  a_r5_cmd_done: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgSel && (|cfgByteEn)) |=> evtRd[EV_CMD]);

  // R4: interlock command inverts interlock state
  a_r4_lock_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgSel && cfgByteEn[CT_LOCK / LANE_W] && lockBit)
      |=> (lockRd != $past(lockRd)));

  // R7: a clear naming an unset event changes no event
  a_r7_guarded_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel && cfgByteEn[0] && (|(evtData & ~evtRd)) && !hotInsert && !attnPress)
      |=> (evtRd == $past(evtRd)));

  // R6: detach leaves the slot empty with link down and a presence change
  a_r6_detach_state: assert property (@(posedge clk) disable iff (!rstN)
    detachReq |-> (!presRd && !linkActive && evtRd[EV_PRES]));

  // R8: insertion result
  a_r8_insert: assert property (@(posedge clk) disable iff (!rstN)
    hotInsert |=> (presRd && linkActive && evtRd[EV_PRES] && evtRd[EV_ATTN]));

  // R11: level line stays low while message interrupts are enabled
  a_r11_level_quiet: assert property (@(posedge clk) disable iff (!rstN)
    msiEnable |=> !intLevel);
endmodule

bind hp_slot_ctrl hp_slot_checker i_hp_slot_checker (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgSel     (cfgSel),
  .cfgByteEn  (cfgByteEn),
  .evtData    (cfgWrData[hp_slot_pkg::EVT_W-1:0]),
  .lockBit    (cfgWrData[hp_slot_pkg::CT_LOCK]),
  .msiEnable  (msiEnable),
  .hotInsert  (hotInsert),
  .attnPress  (attnPress),
  .evtRd      (staRdData[hp_slot_pkg::EVT_W-1:0]),
  .presRd     (staRdData[hp_slot_pkg::ST_PRESENT]),
  .lockRd     (staRdData[hp_slot_pkg::ST_LOCK]),
  .linkActive (linkActive),
  .intLevel   (intLevel),
  .detachReq  (detachReq)
);

// File: tb/test_hp_slot_ctrl.sv
`timescale 1ns/1ps
module test_hp_slot_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgSel = 1'b0;
  logic [1:0]  cfgByteEn = 2'b00;
  logic [15:0] cfgWrData = 16'h0;
  logic        msiEnable = 1'b0, hotInsert = 1'b0, attnPress = 1'b0;
  logic [15:0] ctlRdData, staRdData;
  logic        linkActive, intLevel, msiReq, detachReq;

  hp_slot_ctrl i_hp_slot_ctrl (.*);

  int checks = 0;
  int failures = 0;

  // bench model state
  logic [15:0] mCtl = 16'h00C0;
  logic [4:0]  mEvt = 5'h0;
  logic mPres = 0, mLock = 0, mLink = 0, mPrev = 0, mInt = 0, mMsi = 0, mDet = 0;

  function automatic logic [15:0] mSta();
    return {8'h00, mLock, mPres, 1'b0, mEvt};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mStep();
    logic cond;
    logic [15:0] nCtl;
    cond = mCtl[5] && (|(mEvt & mCtl[4:0]));
    mMsi = msiEnable && (cond != mPrev);
    mInt = !msiEnable && cond;
    mPrev = cond;
    mDet = 1'b0;
    if (cfgWrEn && cfgSel && cfgByteEn[0] && ((cfgWrData[4:0] & ~mEvt) == 5'h0))
      mEvt = mEvt & ~cfgWrData[4:0];
    if (cfgWrEn && !cfgSel && cfgByteEn != 2'b00) begin
      nCtl = mCtl;
      if (cfgByteEn[0]) nCtl[7:0] = cfgWrData[7:0];
      if (cfgByteEn[1]) begin
        nCtl[10:8] = cfgWrData[10:8];
        if (cfgWrData[11]) mLock = !mLock;
      end
      if (mPres && nCtl[10] && nCtl[9:8] == 2'b11 && !(mCtl[10] && mCtl[9:8] == 2'b11)) begin
        mPres = 0; mLink = 0; mEvt[3] = 1'b1; mDet = 1'b1;
      end
      mCtl = nCtl;
      mEvt[4] = 1'b1;
    end
    if (hotInsert) begin mPres = 1; mLink = 1; mEvt = mEvt | 5'h09; end
    if (attnPress) mEvt[0] = 1'b1;
  endtask

  task automatic compareAll();
    chk("R2 command register", ctlRdData, mCtl);
    chk("R3 status register", staRdData, mSta());
    chk("R8 linkActive", {15'h0, linkActive}, {15'h0, mLink});
    chk("R10 intLevel", {15'h0, intLevel}, {15'h0, mInt});
    chk("R11 msiReq", {15'h0, msiReq}, {15'h0, mMsi});
    chk("R6 detachReq", {15'h0, detachReq}, {15'h0, mDet});
  endtask

  task automatic tick();
    @(posedge clk);
    mStep();
    @(negedge clk);
    compareAll();
    cfgWrEn = 0; cfgSel = 0; cfgByteEn = 2'b00; cfgWrData = 16'h0;
    hotInsert = 0; attnPress = 0;
  endtask

  task automatic wrCtl(logic [1:0] be, logic [15:0] d);
    cfgWrEn = 1; cfgSel = 0; cfgByteEn = be; cfgWrData = d; tick();
  endtask
  task automatic wrSta(logic [15:0] d);
    cfgWrEn = 1; cfgSel = 1; cfgByteEn = 2'b01; cfgWrData = d; tick();
  endtask

  task automatic finish();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 command reset", ctlRdData, 16'h00C0);
    chk("R1 status reset", staRdData, 16'h0000);
    chk("R1 outputs reset", {12'h0, linkActive, intLevel, msiReq, detachReq}, 16'h0);
    rstN = 1;

    wrCtl(2'b11, 16'hF828);              // master + presence enable, upper junk and lock
    chk("R2 ctl write masks upper bits", ctlRdData, 16'h0028);
    chk("R5 command done set", {15'h0, staRdData[4]}, 16'h1);
    chk("R4 lock toggled by command", {15'h0, staRdData[7]}, 16'h1);
    wrCtl(2'b10, 16'h0800);
    chk("R4 lock toggled back", {15'h0, staRdData[7]}, 16'h0);
    wrSta(16'h0010);
    chk("R3 command done cleared", staRdData, 16'h0000);

    hotInsert = 1; tick();
    chk("R8 insertion status", staRdData, 16'h0049);
    chk("R8 link active", {15'h0, linkActive}, 16'h1);
    tick();
    chk("R10 level interrupt raised", {15'h0, intLevel}, 16'h1);

    msiEnable = 1; tick();
    chk("R11 level off under msi", {15'h0, intLevel}, 16'h0);
    chk("R11 no msi without change", {15'h0, msiReq}, 16'h0);
    wrSta(16'h0009);
    tick();
    chk("R11 msi on falling condition", {15'h0, msiReq}, 16'h1);
    tick();
    chk("R11 msi single cycle", {15'h0, msiReq}, 16'h0);

    wrCtl(2'b01, 16'h0029);              // add attention enable
    attnPress = 1; tick();
    tick();
    chk("R9 msi on attention", {15'h0, msiReq}, 16'h1);
    attnPress = 1; tick();
    tick();
    chk("R9 repeat attention silent", {15'h0, msiReq}, 16'h0);

    wrSta(16'h001F);
    chk("R7 guarded clear keeps events", staRdData, 16'h0051);
    wrSta(16'h0001);
    chk("R7 valid clear", staRdData, 16'h0050);

    wrCtl(2'b01, 16'h00FF);
    chk("R2 low lane only", ctlRdData, 16'h00FF);
    wrCtl(2'b10, 16'hF700);
    chk("R6 detach pulse", {15'h0, detachReq}, 16'h1);
    chk("R6 detach status", staRdData & 16'h0048, 16'h0008);
    chk("R6 link down", {15'h0, linkActive}, 16'h0);
    hotInsert = 1; tick();
    wrCtl(2'b10, 16'h0700);
    chk("R6 no detach when already off", {15'h0, detachReq}, 16'h0);
    chk("R6 still present", {15'h0, staRdData[6]}, 16'h1);
    msiEnable = 0;

    for (int n = 0; n < 4000; n++) begin
      int op;
      op = int'($urandom % 16);
      if (op < 4) begin
        cfgWrEn = 1; cfgSel = 0;
        cfgByteEn = 2'($urandom);
        cfgWrData = 16'($urandom);
        if ($urandom % 2 == 0) cfgWrData[10:8] = 3'b111;
      end else if (op < 7) begin
        cfgWrEn = 1; cfgSel = 1;
        cfgByteEn = 2'($urandom);
        cfgWrData = 16'($urandom);
      end else if (op == 7) hotInsert = 1;
      else if (op == 8) attnPress = 1;
      else if (op == 9) msiEnable = !msiEnable;
      tick();
    end
    finish();
  end
endmodule